// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front-End

This block is the software-facing side of an SPI controller. A single-cycle register port gives software access to a control word, a clock setup word, transmit and receive word formats, frame-select settings, a status word, interrupt enables, write-one-to-clear interrupt flags and a FIFO control word. A serial engine sits behind the block. It draws transmit words from an internal FIFO, returns received words into a second FIFO, and takes its settings from decoded configuration outputs.

Both FIFOs are reached through one data offset. A write to that offset queues a word for transmission, and a read from it takes the oldest received word. Software first waits until the busy bit clears, then checks the not-full or not-empty bit before each data access. The engine reports the end of a transmit word, the end of a receive word and arriving receive data. A receive word that arrives while its FIFO is full is counted as an overrun. The enabled flags are ORed onto one interrupt line.

Top module: `spi_regfront`

## Requirements
- R1: After reset, every readable register returns 0, except the status word at 0x14, which returns 0x20 (transmit not full). The interrupt line is low and the engine sees no transmit word.
- R2: With the enable bit clear, the configuration registers read back exactly what was written through these masks and drive the matching outputs. The masks are: clock word 0x04 with divider in bits 7:0, capture phase in bit 14, idle level in bit 13 and delay in bit 12; transmit format 0x08 with bits 13:0; receive format 0x0C with bits 7:0; frame word 0x10 with polarity in bit 15 and start edge in bit 14; interrupt enable 0x18 with bits 4, 3 and 0.
- R3: While bit 0 of the control word at 0x00 is 1, writes to offsets 0x04, 0x08, 0x0C and 0x10 are ignored. The control word itself stays writable.
- R4: A write to the data offset 0x24 queues the word. The engine receives queued words in write order, and its valid output stays high while any word is queued.
- R5: The transmit FIFO holds FIFO_DEPTH words. A data write while it is full is ignored.
- R6: A read of 0x24 returns the oldest received word and removes it. A read while the receive FIFO is empty returns 0 and changes nothing.
- R7: A receive word pushed while the receive FIFO is full is dropped and sets the overrun flag (bit 0).
- R8: In the FIFO control word at 0x20, writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO, both effective from the next cycle. These two bits read back as 0. The transmit threshold is held in bits 11:8 and the receive threshold in bits 3:0, and both drive outputs.
- R9: The status word at 0x14 shows engine busy in bit 7, transmit not full in bit 5 and receive not empty in bit 0.
- R10: The engine's transmit-done pulse sets flag bit 4, its receive-done pulse sets bit 3, and an overrun sets bit 0. Reading 0x1C returns the flags. Writing 1s to 0x1C clears the matching flags. A set and a clear of the same flag in the same cycle leave the flag set.
- R11: The interrupt output is high exactly when some flag is set and its enable bit at 0x18 (bits 4, 3, 0) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| eng_busy | input | 1 | Serial engine is shifting |
| eng_tx_valid | output | 1 | A transmit word is queued |
| eng_tx_data | output | DATA_W | Oldest queued transmit word |
| eng_tx_pop | input | 1 | Engine takes the transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_tx_done | input | 1 | Pulse: transmit word finished |
| eng_rx_done | input | 1 | Pulse: receive word finished |
| cfg_enable | output | 1 | Controller enable |
| cfg_clk_div | output | 8 | Clock divider |
| cfg_clk_mode | output | 3 | {capture phase, idle level, delay} |
| cfg_frame_mode | output | 2 | {frame polarity, start edge} |
| cfg_tx_fmt | output | 14 | {word length, order, data length} for transmit |
| cfg_rx_fmt | output | 8 | {order, data length} for receive |
| cfg_tx_thresh | output | 4 | Transmit FIFO threshold |
| cfg_rx_thresh | output | 4 | Receive FIFO threshold |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 32-bit words and a depth of 8. With a depth of 8, every fill level from empty to two past full is reachable in a short sweep on both FIFOs, so the full boundary, the dropped write, the overrun and the empty read are each hit directly. The interrupt check covers all eight flag combinations against all eight enable masks. The expected line level is computed as the AND of the two masks.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam logic [5:0] OFS_CTRL    = 6'h00;
    localparam logic [5:0] OFS_CLK     = 6'h04;
    localparam logic [5:0] OFS_TXFMT   = 6'h08;
    localparam logic [5:0] OFS_RXFMT   = 6'h0C;
    localparam logic [5:0] OFS_FRAME   = 6'h10;
    localparam logic [5:0] OFS_STATUS  = 6'h14;
    localparam logic [5:0] OFS_IRQEN   = 6'h18;
    localparam logic [5:0] OFS_IRQFLAG = 6'h1C;
    localparam logic [5:0] OFS_FIFOCTL = 6'h20;
    localparam logic [5:0] OFS_DATA    = 6'h24;

    localparam int NUM_FLAGS = 3;

    // Flag vector order: [2] transmit done, [1] receive done, [0] overrun
    typedef struct packed {
        logic        enable;
        logic [7:0]  clk_div;
        logic [2:0]  clk_mode;
        logic [13:0] tx_fmt;
        logic [7:0]  rx_fmt;
        logic [1:0]  frame_mode;
        logic [2:0]  irq_en;
        logic [3:0]  tx_thr;
        logic [3:0]  rx_thr;
    } cfg_regs_t;

    function automatic logic [2:0] flags_from_word(input logic [31:0] w);
        return {w[4], w[3], w[0]};
    endfunction

    function automatic logic [31:0] flags_to_word(input logic [2:0] f);
        logic [31:0] w;
        w    = '0;
        w[4] = f[2];
        w[3] = f[1];
        w[0] = f[0];
        return w;
    endfunction

endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    input  logic                           flush,
    output logic [WIDTH-1:0]               head,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (st_q.count == CNT_W'(DEPTH));
    assign empty = (st_q.count == '0);
    assign level = st_q.count;
    assign head  = mem_q[st_q.rd_ptr];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= push_data;
    end

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    assert_full_push_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(level)));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/spi_regfront_irq.sv
module spi_regfront_irq #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    typedef struct packed {
        logic [NF-1:0] flags;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign irq   = |(st_q.flags & en);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));

    assert_clear_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((flags & $past(clr) & ~$past(set)) == '0));

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_busy,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_tx_done,
    input  logic              eng_rx_done,
    output logic              cfg_enable,
    output logic [7:0]        cfg_clk_div,
    output logic [2:0]        cfg_clk_mode,
    output logic [1:0]        cfg_frame_mode,
    output logic [13:0]       cfg_tx_fmt,
    output logic [7:0]        cfg_rx_fmt,
    output logic [3:0]        cfg_tx_thresh,
    output logic [3:0]        cfg_rx_thresh,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int RD_W  = (DATA_W < 32) ? DATA_W : 32;

    cfg_regs_t regs_d, regs_q;

    logic acc_wr, acc_rd;
    logic hit_data, hit_fifoctl, hit_irqflag;
    logic tx_push, tx_flush, rx_pop, rx_flush;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [CNT_W-1:0]  tx_level, rx_level;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_vec;

    assign acc_wr      = bus_sel && bus_wr;
    assign acc_rd      = bus_sel && !bus_wr;
    assign hit_data    = (bus_addr == ADDR_W'(OFS_DATA));
    assign hit_fifoctl = (bus_addr == ADDR_W'(OFS_FIFOCTL));
    assign hit_irqflag = (bus_addr == ADDR_W'(OFS_IRQFLAG));

    assign tx_push  = acc_wr && hit_data;
    assign rx_pop   = acc_rd && hit_data;
    assign tx_flush = acc_wr && hit_fifoctl && bus_wdata[12];
    assign rx_flush = acc_wr && hit_fifoctl && bus_wdata[4];

    assign flag_set = {eng_tx_done, eng_rx_done, eng_rx_push && rx_full};
    assign flag_clr = (acc_wr && hit_irqflag) ? flags_from_word(bus_wdata) : '0;

    // Register update: configuration words are locked while enabled
    always_comb begin
        regs_d = regs_q;
        if (acc_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_CTRL): regs_d.enable = bus_wdata[0];
                ADDR_W'(OFS_CLK): begin
                    if (!regs_q.enable) begin
                        regs_d.clk_div  = bus_wdata[7:0];
                        regs_d.clk_mode = bus_wdata[14:12];
                    end
                end
                ADDR_W'(OFS_TXFMT): begin
                    if (!regs_q.enable) regs_d.tx_fmt = bus_wdata[13:0];
                end
                ADDR_W'(OFS_RXFMT): begin
                    if (!regs_q.enable) regs_d.rx_fmt = bus_wdata[7:0];
                end
                ADDR_W'(OFS_FRAME): begin
                    if (!regs_q.enable) regs_d.frame_mode = bus_wdata[15:14];
                end
                ADDR_W'(OFS_IRQEN): regs_d.irq_en = flags_from_word(bus_wdata);
                ADDR_W'(OFS_FIFOCTL): begin
                    regs_d.tx_thr = bus_wdata[11:8];
                    regs_d.rx_thr = bus_wdata[3:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Read multiplexer, valid in the access cycle
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):    bus_rdata[0] = regs_q.enable;
            ADDR_W'(OFS_CLK): begin
                bus_rdata[7:0]   = regs_q.clk_div;
                bus_rdata[14:12] = regs_q.clk_mode;
            end
            ADDR_W'(OFS_TXFMT):   bus_rdata[13:0] = regs_q.tx_fmt;
            ADDR_W'(OFS_RXFMT):   bus_rdata[7:0]  = regs_q.rx_fmt;
            ADDR_W'(OFS_FRAME):   bus_rdata[15:14] = regs_q.frame_mode;
            ADDR_W'(OFS_STATUS): begin
                bus_rdata[7] = eng_busy;
                bus_rdata[5] = !tx_full;
                bus_rdata[0] = !rx_empty;
            end
            ADDR_W'(OFS_IRQEN):   bus_rdata = flags_to_word(regs_q.irq_en);
            ADDR_W'(OFS_IRQFLAG): bus_rdata = flags_to_word(flag_vec);
            ADDR_W'(OFS_FIFOCTL): begin
                bus_rdata[11:8] = regs_q.tx_thr;
                bus_rdata[3:0]  = regs_q.rx_thr;
            end
            ADDR_W'(OFS_DATA): begin
                if (!rx_empty) bus_rdata[RD_W-1:0] = rx_head[RD_W-1:0];
            end
            default: ;
        endcase
    end

    spi_regfront_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (bus_wdata[DATA_W-1:0]),
        .pop       (eng_tx_pop),
        .flush     (tx_flush),
        .head      (eng_tx_data),
        .full      (tx_full),
        .empty     (tx_empty),
        .level     (tx_level)
    );

    spi_regfront_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .flush     (rx_flush),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty),
        .level     (rx_level)
    );

    spi_regfront_irq #(.NF(NUM_FLAGS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .en    (regs_q.irq_en),
        .flags (flag_vec),
        .irq   (irq)
    );

    assign eng_tx_valid   = !tx_empty;
    assign cfg_enable     = regs_q.enable;
    assign cfg_clk_div    = regs_q.clk_div;
    assign cfg_clk_mode   = regs_q.clk_mode;
    assign cfg_frame_mode = regs_q.frame_mode;
    assign cfg_tx_fmt     = regs_q.tx_fmt;
    assign cfg_rx_fmt     = regs_q.rx_fmt;
    assign cfg_tx_thresh  = regs_q.tx_thr;
    assign cfg_rx_thresh  = regs_q.rx_thr;

    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && cfg_enable && (bus_addr == ADDR_W'(OFS_CLK)))
        |=> ($stable(cfg_clk_div) && $stable(cfg_clk_mode)));

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> (bus_rdata == '0));

    assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full) |=> flag_vec[0]);

    assert_tx_push_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_full && !eng_tx_pop && !tx_flush) |=> (tx_level == $past(tx_level) + 1'b1));

endmodule

// File: tb/test_spi_regfront.sv
module test_spi_regfront;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic eng_busy = 0, eng_tx_valid, eng_tx_pop = 0, eng_rx_push = 0;
    logic [31:0] eng_tx_data, eng_rx_data = '0;
    logic eng_tx_done = 0, eng_rx_done = 0;
    logic cfg_enable, irq;
    logic [7:0] cfg_clk_div, cfg_rx_fmt;
    logic [2:0] cfg_clk_mode;
    logic [1:0] cfg_frame_mode;
    logic [13:0] cfg_tx_fmt;
    logic [3:0] cfg_tx_thresh, cfg_rx_thresh;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfront i_spi_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done),
        .cfg_enable(cfg_enable), .cfg_clk_div(cfg_clk_div), .cfg_clk_mode(cfg_clk_mode),
        .cfg_frame_mode(cfg_frame_mode), .cfg_tx_fmt(cfg_tx_fmt), .cfg_rx_fmt(cfg_rx_fmt),
        .cfg_tx_thresh(cfg_tx_thresh), .cfg_rx_thresh(cfg_rx_thresh), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rx_in(input logic [31:0] d);
        @(negedge clk);
        eng_rx_push = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic tx_take(output logic v, output logic [31:0] d);
        @(negedge clk);
        #1 v = eng_tx_valid; d = eng_tx_data;
        eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic v;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a <= 9; a++) begin
            rd(6'(a * 4), rv);
            check("R1", rv, (a == 5) ? 32'h20 : 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 tx_valid", {31'b0, eng_tx_valid}, 0);

        // R2 config read-back under masks
        wr(6'h04, 32'hFFFF_FFA5); rd(6'h04, rv); check("R2 clk", rv, 32'h0000_70A5);
        check("R2 clk_div", {24'b0, cfg_clk_div}, 32'hA5);
        check("R2 clk_mode", {29'b0, cfg_clk_mode}, 7);
        wr(6'h08, 32'hFFFF_2A5B); rd(6'h08, rv); check("R2 txfmt", rv, 32'h2A5B);
        check("R2 tx_fmt out", {18'b0, cfg_tx_fmt}, 32'h2A5B);
        wr(6'h0C, 32'hFFFF_FF47); rd(6'h0C, rv); check("R2 rxfmt", rv, 32'h47);
        wr(6'h10, 32'hFFFF_BFFF); rd(6'h10, rv); check("R2 frame", rv, 32'h8000);
        check("R2 frame out", {30'b0, cfg_frame_mode}, 2);
        wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, rv); check("R2 irqen", rv, 32'h19);
        wr(6'h18, 0);

        // R3 lock while enabled
        wr(6'h00, 1); check("R3 enable", {31'b0, cfg_enable}, 1);
        wr(6'h04, 32'h0000_0011); rd(6'h04, rv); check("R3 clk locked", rv, 32'h70A5);
        wr(6'h08, 0); rd(6'h08, rv); check("R3 txfmt locked", rv, 32'h2A5B);
        wr(6'h10, 0); check("R3 frame locked", {30'b0, cfg_frame_mode}, 2);
        wr(6'h00, 0); rd(6'h00, rv); check("R3 ctrl writable", rv, 0);
        wr(6'h04, 32'h0000_1011); rd(6'h04, rv); check("R3 unlocked", rv, 32'h1011);

        // R4 R5 R9 transmit fill sweep
        for (int n = 0; n <= DEPTH + 2; n++) begin
            wr(6'h20, 32'h1000);
            for (int k = 0; k < n; k++) wr(6'h24, 32'h100 + k);
            rd(6'h14, rv);
            check("R9 tx not full", rv & 32'h20, (n < DEPTH) ? 32'h20 : 0);
            for (int k = 0; k < ((n < DEPTH) ? n : DEPTH); k++) begin
                tx_take(v, d);
                check("R4 tx valid", {31'b0, v}, 1);
                check("R5 tx order", d, 32'h100 + k);
            end
            check("R5 tx drained", {31'b0, eng_tx_valid}, 0);
        end

        // R6 R7 R9 receive fill sweep
        for (int n = 0; n <= DEPTH + 2; n++) begin
            wr(6'h20, 32'h10);
            wr(6'h1C, 32'h19);
            for (int k = 0; k < n; k++) rx_in(32'hA000 + k);
            rd(6'h14, rv);
            check("R9 rx not empty", rv & 32'h1, (n > 0) ? 1 : 0);
            rd(6'h1C, rv);
            check("R7 overrun", rv & 32'h1, (n > DEPTH) ? 1 : 0);
            for (int k = 0; k <= ((n < DEPTH) ? n : DEPTH); k++) begin
                rd(6'h24, rv);
                check("R6 rx data", rv, (k < n && k < DEPTH) ? 32'hA000 + k : 0);
            end
        end

        // R8 flush and thresholds
        wr(6'h24, 32'h55); rx_in(32'h66);
        wr(6'h20, 32'h0000_1A15);
        rd(6'h20, rv); check("R8 fifoctl", rv, 32'h0A05);
        check("R8 tx thresh", {28'b0, cfg_tx_thresh}, 32'hA);
        check("R8 rx thresh", {28'b0, cfg_rx_thresh}, 32'h5);
        rd(6'h14, rv); check("R8 status after flush", rv, 32'h20);
        check("R8 tx empty", {31'b0, eng_tx_valid}, 0);

        // R9 busy
        eng_busy = 1; rd(6'h14, rv); check("R9 busy", rv & 32'h80, 32'h80);
        eng_busy = 0;

        // R10 flags, W1C, set wins
        wr(6'h1C, 32'h19);
        @(negedge clk); eng_tx_done = 1; @(negedge clk); eng_tx_done = 0;
        rd(6'h1C, rv); check("R10 tx flag", rv, 32'h10);
        @(negedge clk); eng_rx_done = 1; @(negedge clk); eng_rx_done = 0;
        wr(6'h1C, 32'h10); rd(6'h1C, rv); check("R10 w1c", rv, 32'h08);
        @(negedge clk);
        eng_rx_done = 1; bus_sel = 1; bus_wr = 1; bus_addr = 6'h1C; bus_wdata = 32'h08;
        @(negedge clk);
        eng_rx_done = 0; bus_sel = 0; bus_wr = 0;
        rd(6'h1C, rv); check("R10 set wins", rv, 32'h08);

        // R11 flags x enables sweep
        for (int f = 0; f < 8; f++) begin
            wr(6'h1C, 32'h19);
            wr(6'h20, 32'h10);
            if (f[2]) begin @(negedge clk); eng_tx_done = 1; @(negedge clk); eng_tx_done = 0; end
            if (f[1]) begin @(negedge clk); eng_rx_done = 1; @(negedge clk); eng_rx_done = 0; end
            if (f[0]) for (int k = 0; k <= DEPTH; k++) rx_in(k);
            for (int e = 0; e < 8; e++) begin
                wr(6'h18, {27'b0, e[2], e[1], 2'b0, e[0]});
                check("R11 irq", {31'b0, irq}, ((f & e) != 0) ? 1 : 0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule